// File: doc/BRIEF.md
# HDLC Frame Receiver

This block turns a serial bit stream into framed bytes. Each received bit arrives with a one-cycle valid strobe. The receiver finds the flag pattern that delimits frames and drops the zeros the transmitter inserted after runs of five ones. It packs the remaining bits into bytes and checks the frame check sequence. It then writes the frame bytes and a closing status byte into a receive FIFO write port, and reports the frame length alongside the status write.

Four static inputs select the behaviour:

- the check width, either 16 bits or 32 bits;
- the value the check register is preset to;
- whether the received check bytes are kept in the FIFO or stripped;
- which end of a stored byte receives the first bit.

A low enable keeps the receiver idle and clears its state. A run of seven ones aborts the current frame. Frames too short to hold a check sequence plus one byte disappear without trace.

Top module: `hdlc_rx_core`

## Requirements
- R1: A frame lies between two flags (bit pattern 0,1,1,1,1,1,1,0). One flag may close a frame and open the next. Back-to-back flags produce no output. Payload bytes are written to the FIFO in arrival order with `fifo_is_status` low.
- R2: A 0 received right after five consecutive 1s is deleted and is not part of the data.
- R3: With `cfg_crc32` at 0 the check sequence is 2 bytes, computed with the reflected polynomial 0x8408. With `cfg_crc32` at 1 it is 4 bytes, computed with 0xEDB88320. The transmitter sends the complemented register least significant bit first. Status bit 0 is 1 only when the register after the check bytes equals 0xF0B8 (16-bit) or 0xDEBB20E3 (32-bit) and the frame held a whole number of bytes.
- R4: At each flag the check register is preset to all ones when `cfg_preset_zero` is 0 and to all zeros when it is 1.
- R5: With `cfg_keep_fcs` at 1, the check bytes are written, in arrival order, after the payload and before the status byte, and `frame_len` counts them. With it at 0 they are not written and not counted.
- R6: With `cfg_msb_first` at 0 the first bit received of a byte lands in bit 0 of the stored byte. With it at 1 the first bit lands in bit 7.
- R7: A seventh consecutive 1 aborts the open frame. If at least one payload byte has been written, a status byte with bit 1 set and bit 0 clear follows, and no check bytes are written. The receiver then ignores the line until the next flag.
- R8: If the bits between the flags are not a multiple of 8, status bit 2 is set and status bit 0 is clear.
- R9: A frame holding no more than the check-sequence byte count (2 or 4) writes nothing at all.
- R10: While `rx_enable` is low, no FIFO write occurs, and after it rises the receiver waits for a flag.
- R11: Status bits 7 to 3 are zero. `frame_len_vld` pulses together with the status write, and `frame_len` then equals the number of non-status bytes written for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_enable | input | 1 | Receiver active when high |
| rx_bit | input | 1 | Received serial bit |
| rx_bit_vld | input | 1 | `rx_bit` is valid this cycle |
| cfg_crc32 | input | 1 | 1: 32-bit check, 0: 16-bit check |
| cfg_preset_zero | input | 1 | 1: preset check register to zeros, 0: to ones |
| cfg_keep_fcs | input | 1 | 1: store received check bytes in the FIFO |
| cfg_msb_first | input | 1 | 1: first received bit is the byte's MSB |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| fifo_is_status | output | 1 | Current write is the status byte |
| frame_len | output | LEN_W | Byte count of the finished frame |
| frame_len_vld | output | 1 | `frame_len` is valid this cycle |

## Verification
A payload byte is written one clock after the bit that completes the byte lying one check-width further on. Check bytes and the status byte follow the last flag bit at one byte per clock, ending between one and five clocks later. The bench therefore drives each frame together with its closing flag and then holds the line quiet for twelve clocks. Only after that does it compare the whole captured write sequence and length against values it computes from the requirements. This keeps every comparison clear of the exact cycle each result lands on.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
   // largest check sequence in bytes (32-bit variant)
   localparam int FCS_BYTES_MAX = 4;
   localparam int FCS16_BYTES   = 2;
   localparam int FCS32_BYTES   = 4;

   // reflected generator polynomials
   localparam logic [15:0] POLY16 = 16'h8408;
   localparam logic [31:0] POLY32 = 32'hEDB88320;

   // register contents after a clean frame plus its complemented check
   localparam logic [15:0] GOOD16 = 16'hF0B8;
   localparam logic [31:0] GOOD32 = 32'hDEBB20E3;

   // line pattern runs
   localparam int RUN_STUFF = 5;
   localparam int RUN_FLAG  = 6;

   // status byte layout
   localparam int ST_OK    = 0;
   localparam int ST_ABORT = 1;
   localparam int ST_RESID = 2;
endpackage

// File: rtl/hdlc_rx_deframe.sv
module hdlc_rx_deframe
   import hdlc_rx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bit_vld,
   input  logic bit_in,
   output logic d_vld,
   output logic d_bit,
   output logic flag_ev,
   output logic abort_ev
);
   // bits that may still turn out to be the start of a flag
   localparam int DLY   = RUN_STUFF + 1;
   localparam int FIL_W = $clog2(DLY + 1);

   logic [2:0]       ones;
   logic             synced;
   logic [DLY-1:0]   dly;
   logic [FIL_W-1:0] fill;
   logic             six_ones;
   logic             push;

   always_comb begin
      flag_ev  = en & bit_vld & ~bit_in & (ones == 3'(RUN_FLAG));
      abort_ev = en & bit_vld &  bit_in & (ones == 3'(RUN_FLAG)) & synced;
      six_ones = bit_vld & bit_in & (ones == 3'(RUN_STUFF));
      push     = en & synced & bit_vld & (ones < 3'(RUN_STUFF));
      d_vld    = push & (fill == FIL_W'(DLY));
      d_bit    = dly[DLY-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones   <= '0;
         synced <= 1'b0;
         dly    <= '0;
         fill   <= '0;
      end else if (!en) begin
         ones   <= '0;
         synced <= 1'b0;
         dly    <= '0;
         fill   <= '0;
      end else if (bit_vld) begin
         if (bit_in) begin
            if (ones != 3'd7) ones <= ones + 3'd1;
         end else begin
            ones <= '0;
         end
         if (flag_ev) begin
            synced <= 1'b1;
            fill   <= '0;
         end else if (abort_ev) begin
            synced <= 1'b0;
            fill   <= '0;
         end else if (six_ones) begin
            fill   <= '0;
         end else if (push) begin
            dly <= {dly[DLY-2:0], bit_in};
            if (fill != FIL_W'(DLY)) fill <= fill + FIL_W'(1);
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_fcs.sv
module hdlc_rx_fcs
   import hdlc_rx_pkg::*;
#(
   parameter int WIDE_EN = 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic step,
   input  logic bit_in,
   input  logic wide,
   input  logic preset_zero,
   output logic match
);
   generate
      if (WIDE_EN != 0) begin : g_w32
         logic [31:0] crc, crc_nx, preset;
         logic        fb;
         always_comb begin
            fb = crc[0] ^ bit_in;
            if (wide) crc_nx = {1'b0, crc[31:1]} ^ (fb ? POLY32 : 32'h0);
            else      crc_nx = {17'h0, crc[15:1]} ^ (fb ? {16'h0, POLY16} : 32'h0);
            if (preset_zero) preset = '0;
            else             preset = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            match = wide ? (crc == GOOD32) : (crc[15:0] == GOOD16);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    crc <= '0;
            else if (load) crc <= preset;
            else if (step) crc <= crc_nx;
         end
      end else begin : g_w16
         logic [15:0] crc, crc_nx;
         logic        fb;
         always_comb begin
            fb     = crc[0] ^ bit_in;
            crc_nx = {1'b0, crc[15:1]} ^ (fb ? POLY16 : 16'h0);
            match  = (crc == GOOD16);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    crc <= '0;
            else if (load) crc <= preset_zero ? 16'h0 : 16'hFFFF;
            else if (step) crc <= crc_nx;
         end
      end
   endgenerate
endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
   import hdlc_rx_pkg::*;
#(
   parameter int LEN_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wide,
   input  logic             keep_fcs,
   input  logic             msb_first,
   input  logic             d_vld,
   input  logic             d_bit,
   input  logic             flag_ev,
   input  logic             abort_ev,
   input  logic             crc_match,
   output logic             crc_load,
   output logic             crc_step,
   output logic             fifo_wr,
   output logic [7:0]       fifo_data,
   output logic             fifo_is_status,
   output logic [LEN_W-1:0] frame_len,
   output logic             frame_len_vld
);
   localparam int IDX_W = $clog2(FCS_BYTES_MAX);
   localparam int CNT_W = $clog2(FCS_BYTES_MAX + 1);

   logic             in_frame;
   logic [2:0]       bitc;
   logic [7:0]       sh, sh_nx;
   logic [7:0]       hold   [FCS_BYTES_MAX];
   logic [7:0]       fl_buf [FCS_BYTES_MAX];
   logic [CNT_W-1:0] fl_left;
   logic [IDX_W-1:0] fl_idx, old_idx;
   logic [LEN_W-1:0] byte_cnt, nfcs, len_q;
   logic             st_pend;
   logic [7:0]       st_byte;
   logic             byte_done, long_enough, resid;

   always_comb begin
      nfcs        = wide ? LEN_W'(FCS32_BYTES) : LEN_W'(FCS16_BYTES);
      old_idx     = wide ? IDX_W'(FCS32_BYTES - 1) : IDX_W'(FCS16_BYTES - 1);
      fl_idx      = fl_left[IDX_W-1:0] - IDX_W'(1);
      sh_nx       = msb_first ? {sh[6:0], d_bit} : {d_bit, sh[7:1]};
      byte_done   = in_frame & d_vld & (bitc == 3'd7);
      long_enough = byte_cnt > nfcs;
      resid       = (bitc != 3'd0);
      crc_load    = flag_ev | ~en;
      crc_step    = in_frame & d_vld;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;   bitc <= '0;      sh <= '0;
         byte_cnt <= '0;     fl_left <= '0;   st_pend <= 1'b0;
         st_byte <= '0;      len_q <= '0;     fifo_wr <= 1'b0;
         fifo_data <= '0;    fifo_is_status <= 1'b0;
         frame_len <= '0;    frame_len_vld <= 1'b0;
         for (int k = 0; k < FCS_BYTES_MAX; k++) begin
            hold[k]   <= '0;
            fl_buf[k] <= '0;
         end
      end else if (!en) begin
         in_frame <= 1'b0;   bitc <= '0;      sh <= '0;
         byte_cnt <= '0;     fl_left <= '0;   st_pend <= 1'b0;
         st_byte <= '0;      len_q <= '0;     fifo_wr <= 1'b0;
         fifo_data <= '0;    fifo_is_status <= 1'b0;
         frame_len <= '0;    frame_len_vld <= 1'b0;
         for (int k = 0; k < FCS_BYTES_MAX; k++) begin
            hold[k]   <= '0;
            fl_buf[k] <= '0;
         end
      end else begin
         fifo_wr        <= 1'b0;
         fifo_is_status <= 1'b0;
         frame_len_vld  <= 1'b0;

         // output sequencer: held check bytes, then status, else payload
         if (fl_left != '0) begin
            fifo_wr   <= 1'b1;
            fifo_data <= fl_buf[fl_idx];
            fl_left   <= fl_left - CNT_W'(1);
         end else if (st_pend) begin
            fifo_wr        <= 1'b1;
            fifo_is_status <= 1'b1;
            fifo_data      <= st_byte;
            frame_len      <= len_q;
            frame_len_vld  <= 1'b1;
            st_pend        <= 1'b0;
         end else if (byte_done && byte_cnt >= nfcs) begin
            fifo_wr   <= 1'b1;
            fifo_data <= hold[old_idx];
         end

         // bit and byte assembly
         if (in_frame && d_vld) begin
            bitc <= bitc + 3'd1;
            sh   <= sh_nx;
            if (bitc == 3'd7) begin
               hold[0] <= sh_nx;
               for (int k = 1; k < FCS_BYTES_MAX; k++) hold[k] <= hold[k-1];
               if (byte_cnt != '1) byte_cnt <= byte_cnt + LEN_W'(1);
            end
         end

         // frame boundaries
         if (flag_ev) begin
            if (in_frame && long_enough) begin
               for (int k = 0; k < FCS_BYTES_MAX; k++) fl_buf[k] <= hold[k];
               fl_left <= keep_fcs ? CNT_W'(nfcs) : '0;
               st_pend <= 1'b1;
               st_byte <= '0;
               st_byte[ST_OK]    <= crc_match & ~resid;
               st_byte[ST_RESID] <= resid;
               len_q   <= keep_fcs ? byte_cnt : byte_cnt - nfcs;
            end
            in_frame <= 1'b1;
            bitc     <= '0;
            sh       <= '0;
            byte_cnt <= '0;
         end else if (abort_ev && in_frame) begin
            if (long_enough) begin
               st_pend <= 1'b1;
               st_byte <= '0;
               st_byte[ST_ABORT] <= 1'b1;
               len_q   <= byte_cnt - nfcs;
               fl_left <= '0;
            end
            in_frame <= 1'b0;
            bitc     <= '0;
            sh       <= '0;
            byte_cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_core.sv
module hdlc_rx_core #(
   parameter int LEN_W    = 12,
   parameter int CRC32_EN = 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_enable,
   input  logic             rx_bit,
   input  logic             rx_bit_vld,
   input  logic             cfg_crc32,
   input  logic             cfg_preset_zero,
   input  logic             cfg_keep_fcs,
   input  logic             cfg_msb_first,
   output logic             fifo_wr,
   output logic [7:0]       fifo_data,
   output logic             fifo_is_status,
   output logic [LEN_W-1:0] frame_len,
   output logic             frame_len_vld
);
   generate
      if (LEN_W < 8 || LEN_W > 24) begin : g_len_bad
         $error("hdlc_rx_core: LEN_W must lie in 8..24");
      end
      if (CRC32_EN != 0 && CRC32_EN != 1) begin : g_crc_bad
         $error("hdlc_rx_core: CRC32_EN must be 0 or 1");
      end
   endgenerate

   logic wide;
   logic d_vld, d_bit, flag_ev, abort_ev;
   logic crc_load, crc_step, crc_match;

   generate
      if (CRC32_EN != 0) begin : g_sel32
         assign wide = cfg_crc32;
      end else begin : g_sel16
         assign wide = 1'b0;
      end
   endgenerate

   hdlc_rx_deframe i_deframe (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rx_enable),
      .bit_vld  (rx_bit_vld),
      .bit_in   (rx_bit),
      .d_vld    (d_vld),
      .d_bit    (d_bit),
      .flag_ev  (flag_ev),
      .abort_ev (abort_ev)
   );

   hdlc_rx_fcs #(.WIDE_EN(CRC32_EN)) i_fcs (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (crc_load),
      .step        (crc_step),
      .bit_in      (d_bit),
      .wide        (wide),
      .preset_zero (cfg_preset_zero),
      .match       (crc_match)
   );

   hdlc_rx_frame #(.LEN_W(LEN_W)) i_frame (
      .clk            (clk),
      .rst_n          (rst_n),
      .en             (rx_enable),
      .wide           (wide),
      .keep_fcs       (cfg_keep_fcs),
      .msb_first      (cfg_msb_first),
      .d_vld          (d_vld),
      .d_bit          (d_bit),
      .flag_ev        (flag_ev),
      .abort_ev       (abort_ev),
      .crc_match      (crc_match),
      .crc_load       (crc_load),
      .crc_step       (crc_step),
      .fifo_wr        (fifo_wr),
      .fifo_data      (fifo_data),
      .fifo_is_status (fifo_is_status),
      .frame_len      (frame_len),
      .frame_len_vld  (frame_len_vld)
   );
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_enable,
   input logic       fifo_wr,
   input logic [7:0] fifo_data,
   input logic       fifo_is_status,
   input logic       frame_len_vld
);
   // R10
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> !fifo_wr);

   // R11
   status_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && fifo_is_status) |-> (fifo_data[7:3] == 5'd0));

   // R11
   len_with_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_len_vld |-> (fifo_wr && fifo_is_status));

   // R11
   status_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_is_status |-> fifo_wr);

   // R1
   status_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && fifo_is_status) |=> !(fifo_wr && fifo_is_status));

   // R7
   abort_not_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && fifo_is_status && fifo_data[1]) |-> !fifo_data[0]);
endmodule

bind hdlc_rx_core hdlc_rx_chk i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rx_enable      (rx_enable),
   .fifo_wr        (fifo_wr),
   .fifo_data      (fifo_data),
   .fifo_is_status (fifo_is_status),
   .frame_len_vld  (frame_len_vld)
);

// File: tb/test_hdlc_rx_core.sv
`timescale 1ns/1ps
module test_hdlc_rx_core;
   localparam int LEN_W = 12;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, rx_enable = 1'b1, rx_bit = 1'b1, rx_bit_vld = 1'b0;
   logic cfg_crc32 = 1'b0, cfg_preset_zero = 1'b0, cfg_keep_fcs = 1'b0, cfg_msb_first = 1'b0;
   logic fifo_wr, fifo_is_status, frame_len_vld;
   logic [7:0] fifo_data;
   logic [LEN_W-1:0] frame_len;

   hdlc_rx_core #(.LEN_W(LEN_W), .CRC32_EN(1)) i_hdlc_rx_core (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_bit(rx_bit),
      .rx_bit_vld(rx_bit_vld), .cfg_crc32(cfg_crc32), .cfg_preset_zero(cfg_preset_zero),
      .cfg_keep_fcs(cfg_keep_fcs), .cfg_msb_first(cfg_msb_first), .fifo_wr(fifo_wr),
      .fifo_data(fifo_data), .fifo_is_status(fifo_is_status), .frame_len(frame_len),
      .frame_len_vld(frame_len_vld));

   int total = 0, bad = 0;
   int tx_ones = 0;

   logic [7:0] got_d [64];
   logic       got_s [64];
   int gn = 0, nlen = 0, got_len = 0;

   logic [7:0] exp_d [64];
   logic       exp_s [64];
   int en_exp = 0, exp_len = 0;

   logic [7:0] pay [16];

   always @(negedge clk) begin
      if (rst_n) begin
         if (fifo_wr && gn < 64) begin
            got_d[gn] = fifo_data;
            got_s[gn] = fifo_is_status;
            gn = gn + 1;
         end
         if (frame_len_vld) begin
            got_len = int'(frame_len);
            nlen = nlen + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      rx_bit = b;
      rx_bit_vld = 1'b1;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      rx_bit_vld = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_dbit(input logic b);
      send_bit(b);
      if (b) begin
         tx_ones++;
         if (tx_ones == 5) begin
            send_bit(1'b0);
            tx_ones = 0;
         end
      end else begin
         tx_ones = 0;
      end
   endtask

   task automatic send_flag();
      for (int i = 0; i < 8; i++) send_bit((i == 0 || i == 7) ? 1'b0 : 1'b1);
      tx_ones = 0;
   endtask

   task automatic send_byte(input logic [7:0] x);
      for (int i = 0; i < 8; i++) send_dbit(x[i]);
   endtask

   function automatic logic [7:0] rev8(input logic [7:0] x);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = x[7-i];
      return r;
   endfunction

   function automatic logic [7:0] cvt(input logic [7:0] x);
      return cfg_msb_first ? rev8(x) : x;
   endfunction

   function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic b, input logic w);
      logic fb;
      fb = c[0] ^ b;
      c = c >> 1;
      if (fb) c = c ^ (w ? 32'hEDB88320 : 32'h0000_8408);
      return c;
   endfunction

   task automatic clear_capture();
      gn = 0;
      nlen = 0;
      en_exp = 0;
      exp_len = 0;
   endtask

   // sends payload + complemented check, optional corruption and extra bits,
   // then the closing flag; fills the expectation for a normal close
   task automatic send_frame(input int pn, input bit corrupt, input int extra);
      logic [31:0] c, fcs;
      int nb;
      nb = cfg_crc32 ? 4 : 2;
      c = cfg_preset_zero ? 32'h0 : (cfg_crc32 ? 32'hFFFF_FFFF : 32'h0000_FFFF);
      for (int i = 0; i < pn; i++)
         for (int j = 0; j < 8; j++) c = crc_bit(c, pay[i][j], cfg_crc32);
      fcs = ~c;
      if (!cfg_crc32) fcs[31:16] = 16'h0;
      if (corrupt) fcs[0] = ~fcs[0];
      for (int i = 0; i < pn; i++) send_byte(pay[i]);
      for (int k = 0; k < nb; k++) send_byte(fcs[8*k +: 8]);
      for (int e = 0; e < extra; e++) send_dbit(e[0]);
      send_flag();
      en_exp = 0;
      for (int i = 0; i < pn; i++) begin
         exp_d[en_exp] = cvt(pay[i]); exp_s[en_exp] = 1'b0; en_exp++;
      end
      if (cfg_keep_fcs)
         for (int k = 0; k < nb; k++) begin
            exp_d[en_exp] = cvt(fcs[8*k +: 8]); exp_s[en_exp] = 1'b0; en_exp++;
         end
      exp_len = en_exp;
      exp_d[en_exp] = corrupt ? 8'h00 : 8'h01;
      exp_s[en_exp] = 1'b1;
      en_exp++;
   endtask

   task automatic compare(input string tp, input string ts);
      int n;
      chk(gn == en_exp, {tp, " write count"}, gn, en_exp);
      n = (gn < en_exp) ? gn : en_exp;
      for (int i = 0; i < n; i++) begin
         if (exp_s[i]) begin
            chk(got_s[i] == 1'b1 && got_d[i] == exp_d[i], {ts, " status byte"},
                {got_s[i], got_d[i]}, {1'b1, exp_d[i]});
         end else if (i >= exp_len - (cfg_keep_fcs ? (cfg_crc32 ? 4 : 2) : 0) && en_exp > 1) begin
            chk(got_s[i] == 1'b0 && got_d[i] == exp_d[i], "R5 check byte",
                {got_s[i], got_d[i]}, {1'b0, exp_d[i]});
         end else begin
            chk(got_s[i] == 1'b0 && got_d[i] == exp_d[i], {tp, " data byte"},
                {got_s[i], got_d[i]}, {1'b0, exp_d[i]});
         end
      end
      chk(nlen == ((en_exp > 0) ? 1 : 0), "R11 length strobe count", nlen, (en_exp > 0) ? 1 : 0);
      if (en_exp > 0 && nlen == 1)
         chk(got_len == exp_len, cfg_keep_fcs ? "R5 R11 frame length" : "R11 frame length",
             got_len, exp_len);
   endtask

   initial begin : watchdog
      #(5.0 * 190000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fifo_wr == 1'b0 && frame_len_vld == 1'b0, "R11 reset state",
          {fifo_wr, frame_len_vld}, 0);

      // sweep of all sixteen configurations
      for (int cfg = 0; cfg < 16; cfg++) begin
         cfg_crc32       = cfg[0];
         cfg_preset_zero = cfg[1];
         cfg_keep_fcs    = cfg[2];
         cfg_msb_first   = cfg[3];
         send_flag();
         idle(4);
         for (int len = 1; len <= 4; len++) begin
            for (int i = 0; i < len; i++) pay[i] = 8'((len * 53 + i * 29 + cfg * 7) & 255);
            if (len == 2) pay[0] = 8'hFF;
            clear_capture();
            if (len == 3) send_flag();   // back-to-back flags: R1
            send_frame(len, 1'b0, 0);
            idle(12);
            compare(cfg_msb_first ? "R6" : "R1", cfg_preset_zero ? "R4 R3" : "R3");
         end
      end

      // directed cases on the basic configuration
      cfg_crc32 = 1'b0; cfg_preset_zero = 1'b0; cfg_keep_fcs = 1'b0; cfg_msb_first = 1'b0;
      send_flag();
      idle(4);

      // R2: long runs of ones need stuffed zeros
      pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h7E; pay[3] = 8'hF8; pay[4] = 8'h1F;
      clear_capture();
      send_frame(5, 1'b0, 0);
      idle(12);
      compare("R2", "R2 R3");

      // R3: damaged check sequence
      pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56;
      clear_capture();
      send_frame(3, 1'b1, 0);
      idle(12);
      compare("R3", "R3 bad check");

      // R8: three spare bits before the flag
      pay[0] = 8'hC3; pay[1] = 8'h3C;
      clear_capture();
      send_frame(2, 1'b0, 3);
      idle(12);
      en_exp = 3; exp_len = 2;
      exp_d[0] = 8'hC3; exp_s[0] = 1'b0;
      exp_d[1] = 8'h3C; exp_s[1] = 1'b0;
      exp_d[2] = 8'h04; exp_s[2] = 1'b1;
      compare("R8", "R8 residual");

      // R7: abort after four bytes, then recovery at the next flag
      clear_capture();
      send_byte(8'hA1); send_byte(8'h5C); send_byte(8'h33); send_byte(8'h00);
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      tx_ones = 0;
      idle(12);
      en_exp = 2; exp_len = 1;
      exp_d[0] = 8'hA1; exp_s[0] = 1'b0;
      exp_d[1] = 8'h02; exp_s[1] = 1'b1;
      compare("R7", "R7 abort");
      clear_capture();
      pay[0] = 8'h99;
      send_byte(8'h55);                 // ignored while hunting
      send_flag();
      send_frame(1, 1'b0, 0);
      idle(12);
      compare("R7", "R7 after resync");

      // R9: frames no longer than the check sequence vanish
      clear_capture();
      send_byte(8'h11); send_byte(8'h22); send_flag();
      send_byte(8'h33); send_flag();
      idle(12);
      chk(gn == 0, "R9 short frame 16-bit", gn, 0);
      cfg_crc32 = 1'b1;
      send_flag();
      clear_capture();
      send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04); send_flag();
      idle(12);
      chk(gn == 0, "R9 short frame 32-bit", gn, 0);
      clear_capture();
      pay[0] = 8'h6D;
      send_frame(1, 1'b0, 0);
      idle(12);
      compare("R9", "R9 R3 minimum frame");
      cfg_crc32 = 1'b0;
      send_flag();
      idle(4);

      // R10: disabled receiver writes nothing, then hunts for a flag
      rx_enable = 1'b0;
      clear_capture();
      pay[0] = 8'h42; pay[1] = 8'h24;
      send_flag();
      send_frame(2, 1'b0, 0);
      idle(12);
      chk(gn == 0, "R10 disabled writes", gn, 0);
      rx_enable = 1'b1;
      clear_capture();
      send_byte(8'h81);                 // before any flag: ignored
      send_flag();
      send_frame(2, 1'b0, 0);
      idle(12);
      compare("R10", "R10 R3 re-enabled");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule